// File: doc/BRIEF.md
# Interrupt request and enable controller

This block collects interrupt requests from fifteen sources and presents at most one of them to the processor core. Each source delivers a one-cycle pulse, and the pulse sets a sticky request bit. A request is recorded whether or not its source is enabled. It stays recorded until software writes it back to 0 or the core acknowledges it.

Software reaches the request bits and the enable bits through a byte-wide register window of four consecutive addresses. Each source has a per-source enable bit. A global disable flag sits on top of the per-source enables. The core raises this flag with its set-disable instruction and lowers it with its clear-disable instruction. The flag is also raised automatically when an interrupt is taken, so a handler cannot be interrupted unless it lowers the flag itself.

The global flag is held in a two-state machine. ST_MASKED means interrupts are blocked. ST_OPEN means interrupts may be taken. Three named transitions connect the states:
- T_UNMASK goes from ST_MASKED to ST_OPEN on clear-disable, provided set-disable is not asserted in the same cycle.
- T_MASK goes from ST_OPEN to ST_MASKED on set-disable.
- T_ACCEPT goes from ST_OPEN to ST_MASKED on an acknowledge while an interrupt is pending.

Reset enters ST_MASKED.

Top module: `irq_gate_ctrl`

## Requirements
- R1: After reset, all request bits and all enable bits read 0 and the global disable flag is set. An enabled request therefore raises no interrupt until clear-disable is issued.
- R2: The register map is as follows. Address 0x3C holds request bits for sources 0 to 7 in bit positions 0 to 7. Address 0x3D holds request bits for sources 8 to 14 in bit positions 0 to 6. Addresses 0x3E and 0x3F hold the enable bits with the same layout. Writes store the byte and reads return it. Any other address reads 0, and writes to it change nothing.
- R3: Bit 7 of 0x3D and bit 7 of 0x3F always read 0, and writes to those bits have no effect.
- R4: A source pulse sets its request bit in the next cycle, even when that source is disabled. The bit stays at 1 until software writes 0 to it or the source is acknowledged.
- R5: irq_pending is 1 exactly when the disable flag is clear and at least one source has both its request bit and its enable bit at 1.
- R6: Set-disable sets the flag and clear-disable clears it, each taking effect from the next cycle. When both are asserted in the same cycle, set-disable wins.
- R7: An acknowledge has effect only while irq_pending is 1. In that case it clears the request bit of the indexed source and sets the disable flag, both from the next cycle. An acknowledge while irq_pending is 0 changes nothing.
- R8: A source pulse in the same cycle as an acknowledge clear of that source, or as a software write to that request bit, leaves the bit at 1.
- R9: irq_index names the lowest-numbered source that is both requested and enabled. Source 0 has the highest priority. Source k at address 0x3C bit b is index b, and source k at address 0x3D bit b is index 8+b. irq_index is 0 while irq_pending is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Register read data (combinational) |
| src_pulse | input | 15 | One-cycle request pulse per source |
| cpu_sei | input | 1 | Set the global disable flag |
| cpu_cli | input | 1 | Clear the global disable flag |
| cpu_ack | input | 1 | Interrupt acknowledge from the core |
| irq_pending | output | 1 | Interrupt request to the core |
| irq_index | output | 4 | Index of the winning source |

## Verification
The assertions check the following on every cycle:
- a pulse always leaves its request bit set, and a set bit holds unless it is written or acknowledged;
- an accepted interrupt always ends in ST_MASKED with its request cleared;
- set-disable always silences irq_pending in the next cycle;
- the winning index is always requested, enabled, and the lowest such source;
- the spare bits always read 0.

Only the bench scenarios can show the register map and the address aliasing. The same holds for the ordering of sources across the two bytes, for set-disable and clear-disable arriving together, and for the retention of a disabled request across several cycles and state changes.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    // Global interrupt disable state
    typedef enum logic {
        ST_MASKED = 1'b0,
        ST_OPEN   = 1'b1
    } mask_state_e;

    // Number of byte registers needed to hold a given number of bits
    function automatic int regs_for(input int nbits, input int reg_w);
        return (nbits + reg_w - 1) / reg_w;
    endfunction

endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
    parameter int NSRC  = 15,
    parameter int REG_W = 8,
    localparam int NREG = irq_gate_pkg::regs_for(NSRC, REG_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NREG-1:0]  req_we,
    input  logic [NREG-1:0]  en_we,
    input  logic [REG_W-1:0] wdata,
    input  logic [NSRC-1:0]  pulse,
    input  logic [NSRC-1:0]  ack_clr,
    output logic [NSRC-1:0]  req_q,
    output logic [NSRC-1:0]  en_q
);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam int RI = i / REG_W;
        localparam int BI = i % REG_W;

        // Request bit: pulse beats write, write beats acknowledge clear
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                req_q[i] <= 1'b0;
            end else if (pulse[i]) begin
                req_q[i] <= 1'b1;
            end else if (req_we[RI]) begin
                req_q[i] <= wdata[BI];
            end else if (ack_clr[i]) begin
                req_q[i] <= 1'b0;
            end
        end

        // Enable bit: software only
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[i] <= 1'b0;
            end else if (en_we[RI]) begin
                en_q[i] <= wdata[BI];
            end
        end

        // R4, R8: a pulse always lands, whatever else happens that cycle
        a_r4_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
            pulse[i] |=> req_q[i]);

        // R4: a set request survives until written or acknowledged
        a_r4_request_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (req_q[i] && !req_we[RI] && !ack_clr[i]) |=> req_q[i]);
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NSRC = 15,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  cand,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Lowest-numbered candidate wins
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    // R9: nothing below the winner is a candidate
    always_comb begin
        if (any) begin
            a_r9_lowest_wins: assert ((cand & ~({NSRC{1'b1}} << idx)) == '0);
        end
    end

endmodule

// File: rtl/irq_mask_fsm.sv
module irq_mask_fsm
    import irq_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic accept,
    output logic masked
);

    mask_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_MASKED;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: T_UNMASK, T_MASK, T_ACCEPT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MASKED: if (clr_req && !set_req) state_d = ST_OPEN;
            ST_OPEN:   if (set_req || accept)   state_d = ST_MASKED;
        endcase
    end

    // Outputs
    always_comb begin
        masked = (state_q == ST_MASKED);
    end

    // R7: taking an interrupt always closes the gate
    a_r7_accept_masks: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state_q == ST_MASKED));

    // R6: set-disable wins over clear-disable
    a_r6_set_masks: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> (state_q == ST_MASKED));

endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl #(
    parameter int NSRC   = 15,
    parameter int REG_W  = 8,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h3C,
    localparam int NREG   = irq_gate_pkg::regs_for(NSRC, REG_W),
    localparam int FLAT_W = NREG * REG_W,
    localparam int IDX_W  = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_we,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [NSRC-1:0]   src_pulse,
    input  logic              cpu_sei,
    input  logic              cpu_cli,
    input  logic              cpu_ack,
    output logic              irq_pending,
    output logic [IDX_W-1:0]  irq_index
);

    logic [NREG-1:0]   req_we, en_we;
    logic [NSRC-1:0]   req_q, en_q, ack_clr;
    logic [FLAT_W-1:0] req_flat, en_flat;
    logic              any_cand, masked, accept;
    logic [IDX_W-1:0]  pick_idx;

    // Write decode: request registers first, enable registers after
    for (genvar k = 0; k < NREG; k++) begin : g_dec
        assign req_we[k] = reg_we && (reg_addr == BASE_ADDR + ADDR_W'(k));
        assign en_we[k]  = reg_we && (reg_addr == BASE_ADDR + ADDR_W'(NREG + k));
    end

    // Read mux, spare bits zero-extended
    assign req_flat = FLAT_W'(req_q);
    assign en_flat  = FLAT_W'(en_q);

    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < NREG; k++) begin
            if (reg_addr == BASE_ADDR + ADDR_W'(k))
                reg_rdata = req_flat[k*REG_W +: REG_W];
            if (reg_addr == BASE_ADDR + ADDR_W'(NREG + k))
                reg_rdata = en_flat[k*REG_W +: REG_W];
        end
    end

    irq_req_bank #(.NSRC(NSRC), .REG_W(REG_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_we  (req_we),
        .en_we   (en_we),
        .wdata   (reg_wdata),
        .pulse   (src_pulse),
        .ack_clr (ack_clr),
        .req_q   (req_q),
        .en_q    (en_q)
    );

    irq_prio_pick #(.NSRC(NSRC)) u_pick (
        .cand (req_q & en_q),
        .any  (any_cand),
        .idx  (pick_idx)
    );

    irq_mask_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (cpu_sei),
        .clr_req (cpu_cli),
        .accept  (accept),
        .masked  (masked)
    );

    assign irq_pending = any_cand && !masked;
    assign irq_index   = irq_pending ? pick_idx : '0;
    assign accept      = cpu_ack && irq_pending;
    assign ack_clr     = accept ? (NSRC'(1) << irq_index) : '0;

    // R5: the winner is both requested and enabled
    a_r5_winner_live: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> (req_q[irq_index] && en_q[irq_index]));

    // R6: set-disable silences the core interface next cycle
    a_r6_sei_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_sei |=> !irq_pending);

    // R7: an accepted source is cleared unless re-requested or rewritten
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !src_pulse[irq_index] && !(|req_we)) |=> !req_q[$past(irq_index)]);

    // R3: spare bits of the last request/enable bytes read 0
    if (NSRC % REG_W != 0) begin : g_spare
        localparam int PAD_LO = NSRC % REG_W;
        a_r3_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
            ((reg_addr == BASE_ADDR + ADDR_W'(NREG - 1)) ||
             (reg_addr == BASE_ADDR + ADDR_W'(2*NREG - 1)))
            |-> ((reg_rdata >> PAD_LO) == '0));
    end

endmodule

// File: tb/tb_irq_gate_ctrl.sv
module tb_irq_gate_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_rdata;
    logic [14:0] src_pulse = '0;
    logic        cpu_sei = 1'b0;
    logic        cpu_cli = 1'b0;
    logic        cpu_ack = 1'b0;
    logic        irq_pending;
    logic [3:0]  irq_index;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int          sel;   // 0: read data, 1: {pending, index}
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always #4 clk = ~clk;

    irq_gate_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_we      (reg_we),
        .reg_rdata   (reg_rdata),
        .src_pulse   (src_pulse),
        .cpu_sei     (cpu_sei),
        .cpu_cli     (cpu_cli),
        .cpu_ack     (cpu_ack),
        .irq_pending (irq_pending),
        .irq_index   (irq_index)
    );

    // Monitor: compares queued expectations mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                item_t it;
                logic [15:0] got;
                it = sb.pop_front();
                got = (it.sel == 0) ? {8'h00, reg_rdata} : {11'b0, irq_pending, irq_index};
                n_chk++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
                end
            end
        end
    end

    // Driver tasks
    task automatic tick();
        @(negedge clk);
        reg_we = 1'b0; src_pulse = '0;
        cpu_sei = 1'b0; cpu_cli = 1'b0; cpu_ack = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        tick();
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        item_t it;
        reg_addr = a;
        it.sel = 0; it.exp = {8'h00, e}; it.tag = tag;
        sb.push_back(it);
        tick();
    endtask

    task automatic chk_irq(input logic p, input logic [3:0] idx, input string tag);
        item_t it;
        it.sel = 1; it.exp = {11'b0, p, idx}; it.tag = tag;
        sb.push_back(it);
        tick();
    endtask

    task automatic pulse(input logic [14:0] m);
        src_pulse = m;
        tick();
    endtask

    task automatic sei();  cpu_sei = 1'b1; tick(); endtask
    task automatic cli();  cpu_cli = 1'b1; tick(); endtask
    task automatic ack();  cpu_ack = 1'b1; tick(); endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Stimulus
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(8'h3C, 8'h00, "R1 req0 reset");
        rd(8'h3D, 8'h00, "R1 req1 reset");
        rd(8'h3E, 8'h00, "R1 en0 reset");
        rd(8'h3F, 8'h00, "R1 en1 reset");
        chk_irq(1'b0, 4'd0, "R1 idle after reset");

        // R1 flag set at reset blocks an enabled request
        wr(8'h3E, 8'hFF);
        pulse(15'h0001);
        chk_irq(1'b0, 4'd0, "R1 masked after reset");
        rd(8'h3C, 8'h01, "R4 pulse latched");
        wr(8'h3E, 8'h00);
        wr(8'h3C, 8'h00);
        rd(8'h3C, 8'h00, "R4 software clear");

        // R4 latch while disabled, R5 gating
        pulse(15'h0010);
        rd(8'h3C, 8'h10, "R4 latched while disabled");
        cli();
        chk_irq(1'b0, 4'd0, "R5 disabled source silent");
        rd(8'h3C, 8'h10, "R4 request persists");
        wr(8'h3E, 8'h10);
        chk_irq(1'b1, 4'd4, "R5 enabled source raises");
        wr(8'h3C, 8'h00);
        chk_irq(1'b0, 4'd0, "R4 cleared by write");

        // R5/R9 priority across bytes
        pulse(15'h0240);
        wr(8'h3E, 8'h40);
        wr(8'h3F, 8'h02);
        chk_irq(1'b1, 4'd6, "R9 lower source wins");
        wr(8'h3E, 8'h00);
        chk_irq(1'b1, 4'd9, "R9 second byte index");

        // R6 set/clear disable
        sei();
        chk_irq(1'b0, 4'd0, "R6 set-disable blocks");
        cpu_sei = 1'b1; cpu_cli = 1'b1; tick();
        chk_irq(1'b0, 4'd0, "R6 set wins over clear");
        cli();
        chk_irq(1'b1, 4'd9, "R6 clear-disable reopens");

        // R7 acknowledge
        ack();
        chk_irq(1'b0, 4'd0, "R7 ack masks");
        rd(8'h3D, 8'h00, "R7 ack clears source");
        rd(8'h3C, 8'h40, "R7 other request kept");
        ack();
        rd(8'h3C, 8'h40, "R7 ack while idle ignored");
        cli();
        chk_irq(1'b0, 4'd0, "R7 ack while idle kept flag path");

        // R8 pulse collisions
        wr(8'h3E, 8'h40);
        chk_irq(1'b1, 4'd6, "R5 pending before collision");
        cpu_ack = 1'b1; src_pulse = 15'h0040; tick();
        rd(8'h3C, 8'h40, "R8 pulse beats ack clear");
        chk_irq(1'b0, 4'd0, "R7 masked after collision ack");
        reg_addr = 8'h3C; reg_wdata = 8'h00; reg_we = 1'b1; src_pulse = 15'h0040; tick();
        rd(8'h3C, 8'h40, "R8 pulse beats write");

        // R3 spare bits
        wr(8'h3F, 8'hFF);
        rd(8'h3F, 8'h7F, "R3 enable spare bit");
        wr(8'h3D, 8'h80);
        rd(8'h3D, 8'h00, "R3 request spare bit");

        // R2 map and aliasing
        wr(8'h3D, 8'h55);
        rd(8'h3D, 8'h55, "R2 request byte write");
        wr(8'h40, 8'hFF);
        rd(8'h40, 8'h00, "R2 unmapped above");
        rd(8'h3B, 8'h00, "R2 unmapped below");
        rd(8'h3C, 8'h40, "R2 req0 untouched");
        rd(8'h3E, 8'h40, "R2 en0 untouched");

        // R9 ordering across all sources
        wr(8'h3E, 8'hFF);
        cli();
        chk_irq(1'b1, 4'd6, "R9 first byte winner");
        wr(8'h3C, 8'h00);
        chk_irq(1'b1, 4'd8, "R9 source 8 index");
        wr(8'h3D, 8'h40);
        chk_irq(1'b1, 4'd14, "R9 last source index");

        tick();
        tick();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule